// File: doc/BRIEF.md
# Timer Control and Status Register Block

This block holds two 32-bit words for a core's three timers: a decrementer, a fixed-interval timer and a watchdog. The control word holds each timer's interrupt enable and its period and mode fields. The control word is also driven out so that the timer engines can use it. The status word gathers events. Each timer engine pulses a set input, and that pulse latches the timer's status bit. Software clears status bits by writing ones to them.

Each timer has one interrupt request. The request is a pure level: its status bit ANDed with its enable bit. Nothing in the core's acceptance of the interrupt clears the request. It falls only when software clears the status bit or drops the enable. If software sets an enable while the matching status bit is already pending, the request rises on the next cycle.

A single-word port accesses the registers. One address bit selects the control word (0) or the status word (1). A write strobe updates the selected word at the clock edge. The read bus shows the selected word combinationally.

Top module: `tmr_csr`

## Requirements
- R1: Asynchronous active-low reset clears both words to zero. While both words are zero, all three interrupt outputs are low.
- R2: A control write stores bits 31:22 of the write data and forces bits 21:0 to zero. The stored bits are period select 31:30, reset mode 29:28, watchdog enable 27, decrementer enable 26, fixed period 25:24, fixed enable 23 and auto-reload 22. From the next cycle the stored word appears on both `ctl_word` and the read bus with `reg_addr`=0.
- R3: The status word has these bits: watchdog-next 31, watchdog pending 30, watchdog reset code 29:28, decrementer pending 27 and fixed pending 26. Pulses on `wdg_next_set`, `wdg_set`, `dec_set` and `fix_set` set bits 31, 30, 27 and 26. `wrs_load` loads `wrs_val` into bits 29:28. Bits 25:0 always read zero.
- R4: A status write clears every defined status bit that is written as 1. Bits written as 0 keep their value. A control write leaves the status word unchanged.
- R5: `dec_irq` equals bit 27 AND enable bit 26. `fix_irq` equals bit 26 AND enable bit 23. `wdg_irq` equals bit 30 AND enable bit 27. The request rises in the cycle after a set pulse when its enable is already on.
- R6: A control write that sets an enable while the matching status bit is pending raises that request in the next cycle.
- R7: A raised request stays asserted for any number of cycles without writes. There is no acknowledge input.
- R8: A status write of 1 to a pending bit lowers its request in the next cycle.
- R9: When a set pulse or `wrs_load` meets a clearing status write to the same bit in the same cycle, the hardware event wins and the bit ends set (or loaded).
- R10: Clearing an enable lowers its request and keeps the status bit pending.
- R11: `reg_rdata` shows the control word when `reg_addr`=0 and the status word when `reg_addr`=1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Word select: 0 control, 1 status |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| dec_set | input | 1 | Decrementer event pulse |
| fix_set | input | 1 | Fixed-interval event pulse |
| wdg_set | input | 1 | Watchdog interrupt event pulse |
| wdg_next_set | input | 1 | Watchdog first-expiry event pulse |
| wrs_load | input | 1 | Load strobe for the watchdog reset code |
| wrs_val | input | 2 | Watchdog reset code to load |
| ctl_word | output | 32 | Current control word for the timer engines |
| dec_irq | output | 1 | Decrementer interrupt request level |
| fix_irq | output | 1 | Fixed-interval interrupt request level |
| wdg_irq | output | 1 | Watchdog interrupt request level |

## Verification
The assertions check several rules on every cycle. A set pulse with its enable on raises the request. Enabling a pending bit raises it. A request holds while no writes occur. Clearing a pending bit lowers its request. The hardware event wins over a clear in the same cycle. Zero-written status bits keep their value. The control word takes the masked write data.

Other behaviour shows only in the bench's scenarios. These cover the zero read-back of the unused bits, the loading of the watchdog reset code, the reset values, the combinational read select, and long random mixes of writes and events checked against a bench model.

// File: rtl/tmr_csr.sv
module tmr_csr #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dec_set,
  input  logic          fix_set,
  input  logic          wdg_set,
  input  logic          wdg_next_set,
  input  logic          wrs_load,
  input  logic [1:0]    wrs_val,
  output logic [DW-1:0] ctl_word,
  output logic          dec_irq,
  output logic          fix_irq,
  output logic          wdg_irq
);
  localparam int BIT_ENW = DW - 1;
  localparam int BIT_WIS = DW - 2;
  localparam int BIT_WRS = DW - 4;
  localparam int BIT_DIS = DW - 5;
  localparam int BIT_FIS = DW - 6;
  localparam int BIT_WIE = DW - 5;
  localparam int BIT_DIE = DW - 6;
  localparam int BIT_FIE = DW - 9;
  localparam logic [DW-1:0] CTL_MASK = {10'h3FF, {(DW-10){1'b0}}};
  localparam logic [DW-1:0] STS_MASK = {6'h3F, {(DW-6){1'b0}}};

  logic [DW-1:0] ctl_q, sts_q, sts_nxt;
  logic          ctl_wr, sts_wr;

  assign ctl_wr = reg_we && !reg_addr;
  assign sts_wr = reg_we && reg_addr;

  always_comb begin
    sts_nxt = sts_q;
    if (sts_wr) sts_nxt = sts_q & ~(reg_wdata & STS_MASK);
    if (wdg_next_set) sts_nxt[BIT_ENW] = 1'b1;
    if (wdg_set)      sts_nxt[BIT_WIS] = 1'b1;
    if (dec_set)      sts_nxt[BIT_DIS] = 1'b1;
    if (fix_set)      sts_nxt[BIT_FIS] = 1'b1;
    if (wrs_load)     sts_nxt[BIT_WRS +: 2] = wrs_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sts_q <= '0;
    end else begin
      if (ctl_wr) ctl_q <= reg_wdata & CTL_MASK;
      sts_q <= sts_nxt;
    end
  end

  assign reg_rdata = reg_addr ? sts_q : ctl_q;
  assign ctl_word  = ctl_q;
  assign dec_irq   = sts_q[BIT_DIS] & ctl_q[BIT_DIE];
  assign fix_irq   = sts_q[BIT_FIS] & ctl_q[BIT_FIE];
  assign wdg_irq   = sts_q[BIT_WIS] & ctl_q[BIT_WIE];
endmodule

// File: rtl/tmr_csr_chk.sv
module tmr_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_addr,
  input logic        reg_we,
  input logic [31:0] reg_wdata,
  input logic        dec_set,
  input logic        fix_set,
  input logic [31:0] ctl_word,
  input logic [31:0] sts_q,
  input logic        dec_irq,
  input logic        fix_irq,
  input logic        wdg_irq
);
  p_ctl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !reg_addr |=> ctl_word == ($past(reg_wdata) & 32'hFFC0_0000));

  p_zero_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr && !reg_wdata[26] && !fix_set |=> sts_q[26] == $past(sts_q[26]));

  p_set_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_set && ctl_word[26] && !(reg_we && !reg_addr) |=> dec_irq);

  p_enable_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !reg_addr && reg_wdata[27] && sts_q[30] |=> wdg_irq);

  p_level_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fix_irq && !reg_we |=> fix_irq);

  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr && reg_wdata[27] && !dec_set |=> !dec_irq);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr && reg_wdata[27] && dec_set |=> sts_q[27]);
endmodule

bind tmr_csr tmr_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .dec_set(dec_set), .fix_set(fix_set),
  .ctl_word(ctl_word), .sts_q(sts_q), .dec_irq(dec_irq),
  .fix_irq(fix_irq), .wdg_irq(wdg_irq)
);

// File: tb/tb_tmr_csr.sv
module tb_tmr_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_addr = 1'b0, reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata, ctl_word;
  logic        dec_set = 0, fix_set = 0, wdg_set = 0, wdg_next_set = 0, wrs_load = 0;
  logic [1:0]  wrs_val = '0;
  logic        dec_irq, fix_irq, wdg_irq;

  int n_vec = 0, n_bad = 0;
  logic [31:0] ctl_m = '0, sts_m = '0;

  always #4 clk = ~clk;

  tmr_csr dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_set(dec_set),
    .fix_set(fix_set), .wdg_set(wdg_set), .wdg_next_set(wdg_next_set),
    .wrs_load(wrs_load), .wrs_val(wrs_val), .ctl_word(ctl_word),
    .dec_irq(dec_irq), .fix_irq(fix_irq), .wdg_irq(wdg_irq)
  );

  function automatic logic [2:0] irq_exp(logic [31:0] c, logic [31:0] s);
    return {s[30] & c[27], s[26] & c[23], s[27] & c[26]};
  endfunction

  function automatic logic [31:0] sts_next(logic [31:0] s, logic we, logic a, logic [31:0] wd,
      logic ds, logic fs, logic ws, logic es, logic wl, logic [1:0] wv);
    logic [31:0] n = s;
    if (we && a) n = s & ~(wd & 32'hFC00_0000);
    if (es) n[31] = 1'b1;
    if (ws) n[30] = 1'b1;
    if (ds) n[27] = 1'b1;
    if (fs) n[26] = 1'b1;
    if (wl) n[29:28] = wv;
    return n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic a, logic [31:0] wd,
      logic ds, logic fs, logic ws, logic es, logic wl, logic [1:0] wv);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    dec_set = ds; fix_set = fs; wdg_set = ws; wdg_next_set = es;
    wrs_load = wl; wrs_val = wv;
    #1;
    chk({tag, " R11 read"}, reg_rdata, a ? sts_m : ctl_m);
    chk({tag, " R5 irq"}, {29'd0, wdg_irq, fix_irq, dec_irq}, {29'd0, irq_exp(ctl_m, sts_m)});
    chk({tag, " R2 ctl"}, ctl_word, ctl_m);
    sts_m = sts_next(sts_m, we, a, wd, ds, fs, ws, es, wl, wv);
    if (we && !a) ctl_m = wd & 32'hFFC0_0000;
  endtask

  task automatic idle(string tag, logic a);
    step(tag, 0, a, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 2'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset ctl", 0);
    idle("R1 reset sts", 1);
    step("R2 ctl all ones", 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 2'd0);
    idle("R2 readback", 0);
    step("R2 ctl clear", 1, 0, 32'h0000_0000, 0, 0, 0, 0, 0, 2'd0);
    step("R3 all sets", 0, 1, 32'h0, 1, 1, 1, 1, 1, 2'd2);
    idle("R3 status view", 1);
    step("R4 write zeros", 1, 1, 32'h03FF_FFFF, 0, 0, 0, 0, 0, 2'd0);
    step("R4 ctl write keeps sts", 1, 0, 32'h0000_0000, 0, 0, 0, 0, 0, 2'd0);
    idle("R4 kept", 1);
    step("R6 enable pending", 1, 0, 32'h0C80_0000, 0, 0, 0, 0, 0, 2'd0);
    idle("R6 raised", 1);
    for (int i = 0; i < 6; i++) idle("R7 hold", i[0]);
    step("R8 clear dec", 1, 1, 32'h0800_0000, 0, 0, 0, 0, 0, 2'd0);
    idle("R8 dec low", 1);
    step("R9 set vs clear", 1, 1, 32'hFC00_0000, 1, 1, 0, 0, 1, 2'd1);
    idle("R9 set won", 1);
    step("R10 drop enables", 1, 0, 32'h0000_0000, 0, 0, 0, 0, 0, 2'd0);
    idle("R10 status kept", 1);
    step("R1 clean", 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 2'd0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step("R5 random", r[1:0] == 2'b00, r[2], $urandom,
           r[5:3] == 3'd0, r[8:6] == 3'd0, r[11:9] == 3'd0,
           r[14:12] == 3'd0, r[17:15] == 3'd0, r[19:18]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule